// File: doc/BRIEF.md
# Multicycle Shared-Memory Processor Core

This block is a small 32-bit processor core that executes a five-class instruction subset over several clock cycles per instruction. The classes are register-to-register arithmetic and logic, move immediate, word load, word store and branch-if-equal. A single word-addressed memory holds both the program and its data, and a multiplexer on the memory address picks either the program counter or the computed address. One ALU serves every arithmetic need: the PC increment, address generation, the branch target and the equality test. Hidden registers (instruction, X, Y, result and memory data) carry values from one step to the next. A hardwired state machine sequences the steps and drives every select, load enable and memory write.

A host side loads the program and data through a dedicated memory port while the `run` input is low, and reads results back through the same port. The core advances one step per clock only while `run` is high. It raises a one-cycle retire pulse in the final step of each instruction and keeps a free-running cycle count. Together these let a caller measure the length of each instruction class.

Top module: `mc_core`

## Requirements
- R1: After reset the PC is 0, the cycle count is 0, the retire pulse is low and the core begins with a fetch.
- R2: A fetch loads the instruction register from the word at the PC and, in the same clock, sets the PC to PC + 4. The retire pulse is high for exactly the final step of every instruction, after which the next fetch follows.
- R3: Opcode 0 in bits [31:26] selects a register operation with rs in [25:21], rt in [20:16], rd in [15:11], bits [10:6] zero and the function code in [5:0]. The codes are 32 add, 34 subtract (rs − rt), 36 and, 37 or, 42 signed set-less-than. The result is written to rd, and the instruction takes 4 clocks.
- R4: Opcode 8 writes the sign-extended 16-bit immediate in bits [15:0] to rt. The rs field is ignored because the base comes from register 0. The instruction takes 4 clocks.
- R5: Opcode 35 loads rt from the word at byte address rs + sign-extended immediate, in 5 clocks.
- R6: Opcode 43 stores rt to the word at byte address rs + sign-extended immediate, in 4 clocks.
- R7: Opcode 4 compares rs with rt. When they are equal, the PC becomes (address of the branch + 4) + 4 × sign-extended immediate; otherwise execution falls through. The instruction takes 3 clocks either way.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: Any other opcode, or opcode 0 with an unlisted function code or a nonzero bits [10:6], retires after 2 clocks and changes no register, memory word or branch state.
- R10: While `run` is low, the PC, the step and the cycle count hold. The host port then writes memory words by word index and reads them combinationally.
- R11: The cycle count rises by one on every clock with `run` high. Memory uses byte addresses whose bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Step enable; low freezes the core |
| host_we | input | 1 | Host write strobe into memory |
| host_addr | input | $clog2(MEM_WORDS) | Host word index |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Word at host_addr |
| pc_o | output | DATA_W | Current program counter |
| retire_o | output | 1 | High in the final step of an instruction |
| cycles_o | output | CNT_W | Clocks executed while running |

## Verification
The assertions assume that the host writes memory only while `run` is low. They also assume that reset is held for at least one clock before the core first runs, so the step, the PC and the count start from known values. The stimulus loads every program and data word with `run` low and reads results back only after `run` drops on a fetch boundary. Every program stays inside the memory and ends either after a counted number of retirements or in a branch to itself, so no fetch runs past the loaded words.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'd0;
    localparam logic [5:0] OPC_BEQ   = 6'd4;
    localparam logic [5:0] OPC_MOVI  = 6'd8;
    localparam logic [5:0] OPC_LOAD  = 6'd35;
    localparam logic [5:0] OPC_STORE = 6'd43;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_EXEC_ALU, ST_EXEC_MEM, ST_MEM_RD,
        ST_MEM_WR, ST_WB_ALU, ST_WB_MEM, ST_BRANCH
    } state_e;

    typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;

    typedef enum logic [1:0] {SRCB_FOUR, SRCB_Y, SRCB_IMM, SRCB_IMMSH} srcb_e;

    typedef struct packed {
        logic    ir_ld;
        logic    pc_ld;
        logic    pc_cond;
        logic    pc_from_res;
        logic    xy_ld;
        logic    res_ld;
        logic    mdr_ld;
        logic    rf_we;
        logic    rf_to_rd;
        logic    rf_from_mdr;
        logic    mem_we;
        logic    addr_res;
        logic    alua_x;
        srcb_e   srcb;
        alu_op_e aluop;
    } ctrl_t;

    function automatic alu_op_e funct_to_op(input logic [5:0] fn);
        case (fn)
            FN_SUB:  return ALU_SUB;
            FN_AND:  return ALU_AND;
            FN_OR:   return ALU_OR;
            FN_SLT:  return ALU_SLT;
            default: return ALU_ADD;
        endcase
    endfunction

endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_op_e       op,
    output logic [DW-1:0] y,
    output logic          zero
);
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(DW-1){1'b0}}, $signed(a) < $signed(b)};
            default: y = a + b;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int DW   = 32,
    parameter int NREG = 32
) (
    input  logic                    clk,
    input  logic [$clog2(NREG)-1:0] raddr_a,
    input  logic [$clog2(NREG)-1:0] raddr_b,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] waddr,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           rdata_a,
    output logic [DW-1:0]           rdata_b
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) regs[waddr] <= wdata;
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/mc_mem.sv
module mc_mem #(
    parameter int DW    = 32,
    parameter int WORDS = 64
) (
    input  logic                     clk,
    input  logic [DW-1:0]            core_addr,
    input  logic                     core_we,
    input  logic [DW-1:0]            core_wdata,
    output logic [DW-1:0]            core_rdata,
    input  logic                     host_we,
    input  logic [$clog2(WORDS)-1:0] host_addr,
    input  logic [DW-1:0]            host_wdata,
    output logic [DW-1:0]            host_rdata
);
    localparam int AW = $clog2(WORDS);

    logic [DW-1:0] words [WORDS];
    logic [AW-1:0] core_idx;
    logic          unused_bits;

    assign core_idx    = core_addr[AW+1:2];
    assign unused_bits = ^{core_addr[1:0], core_addr[DW-1:AW+2]};

    always_ff @(posedge clk) begin
        if (core_we)      words[core_idx]  <= core_wdata;
        else if (host_we) words[host_addr] <= host_wdata;
    end

    assign core_rdata = words[core_idx];
    assign host_rdata = words[host_addr];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [5:0] opcode,
    input  logic [4:0] shamt,
    input  logic [5:0] funct,
    output ctrl_t      ctl,
    output state_e     state,
    output logic       retire
);
    state_e state_q, state_d;
    logic   r_ok;

    always_comb begin
        r_ok = (shamt == '0) && (funct inside {FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT});
        ctl     = '0;
        state_d = state_q;
        retire  = 1'b0;
        case (state_q)
            ST_FETCH: begin
                ctl.ir_ld = 1'b1;
                ctl.pc_ld = 1'b1;
                ctl.srcb  = SRCB_FOUR;
                state_d   = ST_DECODE;
            end
            ST_DECODE: begin
                ctl.xy_ld  = 1'b1;
                ctl.res_ld = 1'b1;
                ctl.srcb   = SRCB_IMMSH;
                case (opcode)
                    OPC_RTYPE: begin
                        state_d = r_ok ? ST_EXEC_ALU : ST_FETCH;
                        retire  = !r_ok;
                    end
                    OPC_MOVI:             state_d = ST_EXEC_ALU;
                    OPC_LOAD, OPC_STORE:  state_d = ST_EXEC_MEM;
                    OPC_BEQ:              state_d = ST_BRANCH;
                    default: begin
                        state_d = ST_FETCH;
                        retire  = 1'b1;
                    end
                endcase
            end
            ST_EXEC_ALU: begin
                ctl.alua_x = 1'b1;
                ctl.res_ld = 1'b1;
                if (opcode == OPC_RTYPE) begin
                    ctl.srcb  = SRCB_Y;
                    ctl.aluop = funct_to_op(funct);
                end else begin
                    ctl.srcb  = SRCB_IMM;
                end
                state_d = ST_WB_ALU;
            end
            ST_WB_ALU: begin
                ctl.rf_we    = 1'b1;
                ctl.rf_to_rd = (opcode == OPC_RTYPE);
                retire       = 1'b1;
                state_d      = ST_FETCH;
            end
            ST_EXEC_MEM: begin
                ctl.alua_x = 1'b1;
                ctl.res_ld = 1'b1;
                ctl.srcb   = SRCB_IMM;
                state_d    = (opcode == OPC_LOAD) ? ST_MEM_RD : ST_MEM_WR;
            end
            ST_MEM_RD: begin
                ctl.addr_res = 1'b1;
                ctl.mdr_ld   = 1'b1;
                state_d      = ST_WB_MEM;
            end
            ST_WB_MEM: begin
                ctl.rf_we       = 1'b1;
                ctl.rf_from_mdr = 1'b1;
                retire          = 1'b1;
                state_d         = ST_FETCH;
            end
            ST_MEM_WR: begin
                ctl.addr_res = 1'b1;
                ctl.mem_we   = 1'b1;
                retire       = 1'b1;
                state_d      = ST_FETCH;
            end
            ST_BRANCH: begin
                ctl.alua_x      = 1'b1;
                ctl.srcb        = SRCB_Y;
                ctl.aluop       = ALU_SUB;
                ctl.pc_cond     = 1'b1;
                ctl.pc_from_res = 1'b1;
                retire          = 1'b1;
                state_d         = ST_FETCH;
            end
            default: state_d = ST_FETCH;
        endcase
        if (!run) begin
            ctl     = '0;
            state_d = state_q;
            retire  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MEM_WORDS = 64,
    parameter int CNT_W     = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         run,
    input  logic                         host_we,
    input  logic [$clog2(MEM_WORDS)-1:0] host_addr,
    input  logic [DATA_W-1:0]            host_wdata,
    output logic [DATA_W-1:0]            host_rdata,
    output logic [DATA_W-1:0]            pc_o,
    output logic                         retire_o,
    output logic [CNT_W-1:0]             cycles_o
);
    localparam int NREG = 32;
    localparam int RIW  = $clog2(NREG);
    localparam int EXT  = DATA_W - 16;
    localparam logic [DATA_W-1:0] FOUR    = DATA_W'(4);
    localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] pc;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] y;
        logic [DATA_W-1:0] res;
        logic [DATA_W-1:0] mdr;
        logic [CNT_W-1:0]  cnt;
    } dp_t;

    dp_t    dp_q, dp_d;
    ctrl_t  ctl;
    state_e st;

    logic [5:0]        opcode;
    logic [RIW-1:0]    rs_idx, rt_idx, rd_idx, wr_idx;
    logic [DATA_W-1:0] imm_sx, imm_sh, alu_a, alu_b, alu_y;
    logic [DATA_W-1:0] rd_a, rd_b, rf_wdata, mem_addr, mem_rdata;
    logic              alu_zero;

    assign opcode = dp_q.ir[31:26];
    assign rs_idx = (opcode == OPC_MOVI) ? '0 : dp_q.ir[25:21];
    assign rt_idx = dp_q.ir[20:16];
    assign rd_idx = dp_q.ir[15:11];
    assign imm_sx = {{EXT{dp_q.ir[15]}}, dp_q.ir[15:0]};
    assign imm_sh = {imm_sx[DATA_W-3:0], 2'b00};

    mc_ctrl ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .opcode (opcode),
        .shamt  (dp_q.ir[10:6]),
        .funct  (dp_q.ir[5:0]),
        .ctl    (ctl),
        .state  (st),
        .retire (retire_o)
    );

    always_comb begin
        alu_a = ctl.alua_x ? dp_q.x : dp_q.pc;
        case (ctl.srcb)
            SRCB_Y:     alu_b = dp_q.y;
            SRCB_IMM:   alu_b = imm_sx;
            SRCB_IMMSH: alu_b = imm_sh;
            default:    alu_b = FOUR;
        endcase
    end

    mc_alu #(.DW(DATA_W)) alu_i (
        .a    (alu_a),
        .b    (alu_b),
        .op   (ctl.aluop),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign wr_idx   = ctl.rf_to_rd ? rd_idx : rt_idx;
    assign rf_wdata = ctl.rf_from_mdr ? dp_q.mdr : dp_q.res;

    mc_regfile #(.DW(DATA_W), .NREG(NREG)) rf_i (
        .clk     (clk),
        .raddr_a (rs_idx),
        .raddr_b (rt_idx),
        .we      (ctl.rf_we),
        .waddr   (wr_idx),
        .wdata   (rf_wdata),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    assign mem_addr = ctl.addr_res ? dp_q.res : dp_q.pc;

    mc_mem #(.DW(DATA_W), .WORDS(MEM_WORDS)) mem_i (
        .clk        (clk),
        .core_addr  (mem_addr),
        .core_we    (ctl.mem_we),
        .core_wdata (dp_q.y),
        .core_rdata (mem_rdata),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    always_comb begin
        dp_d = dp_q;
        if (ctl.ir_ld) dp_d.ir = mem_rdata;
        if (ctl.pc_ld || (ctl.pc_cond && alu_zero))
            dp_d.pc = ctl.pc_from_res ? dp_q.res : alu_y;
        if (ctl.xy_ld) begin
            dp_d.x = rd_a;
            dp_d.y = rd_b;
        end
        if (ctl.res_ld) dp_d.res = alu_y;
        if (ctl.mdr_ld) dp_d.mdr = mem_rdata;
        if (run)        dp_d.cnt = dp_q.cnt + CNT_ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign pc_o     = dp_q.pc;
    assign cycles_o = dp_q.cnt;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
    import mc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              retire,
    input state_e            state,
    input logic [DATA_W-1:0] pc,
    input logic [CNT_W-1:0]  cnt
);
    localparam logic [DATA_W-1:0] PC_STEP = DATA_W'(4);
    localparam logic [CNT_W-1:0]  ONE     = CNT_W'(1);

    assert_cnt_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (cnt == $past(cnt) + ONE))
        else $error("cycle count did not advance");

    assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(pc) && $stable(state) && $stable(cnt)))
        else $error("core moved while stopped");

    assert_fetch_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state == ST_FETCH) |=> (pc == $past(pc) + PC_STEP))
        else $error("fetch did not advance pc by 4");

    assert_retire_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && retire) |=> (state == ST_FETCH))
        else $error("retire not followed by fetch");

    assert_branch_retires_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state == ST_BRANCH) |-> retire)
        else $error("branch step did not retire");

    assert_load_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state == ST_MEM_RD) |=> (state == ST_WB_MEM && !$past(retire)))
        else $error("load read step not followed by write-back");
endmodule

bind mc_core mc_core_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .retire (retire_o),
    .state  (st),
    .pc     (pc_o),
    .cnt    (cycles_o)
);

// File: tb/mc_core_tb.sv
`timescale 1ns/1ps
module mc_core_tb_top;
    localparam int WORDS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        host_we = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [31:0] pc_o;
    logic        retire_o;
    logic [31:0] cycles_o;

    int tests = 0;
    int fails = 0;
    int lens [16];

    always #2 clk = ~clk;

    mc_core #(.DATA_W(32), .MEM_WORDS(WORDS), .CNT_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .run(run),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .pc_o(pc_o), .retire_o(retire_o), .cycles_o(cycles_o)
    );

    function automatic logic [31:0] rr(input int fn, input int rs, input int rt, input int rd);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
    endfunction

    function automatic logic [31:0] ii(input int op, input int rs, input int rt, input int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input int waddr, input logic [31:0] w);
        @(negedge clk);
        host_we = 1'b1; host_addr = waddr[5:0]; host_wdata = w;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic peek(input int waddr, output logic [31:0] w);
        host_addr = waddr[5:0];
        #1 w = host_rdata;
    endtask

    task automatic do_reset();
        run = 1'b0; rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic run_prog(input int n);
        int prev = -1;
        int k = 0;
        int guard = 0;
        run = 1'b1;
        while (k < n && guard < 2000) begin
            @(negedge clk);
            guard++;
            if (retire_o) begin
                lens[k] = int'(cycles_o) - prev;
                prev = int'(cycles_o);
                k++;
            end
        end
        if (k < n) begin
            tests++; fails++;
            $display("FAIL R2: program stalled, got %0d retires expected %0d", k, n);
        end
        @(posedge clk);
        #1 run = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 pc", pc_o, 32'd0);
        chk("R1 cycles", cycles_o, 32'd0);
        chk("R1 retire", {31'd0, retire_o}, 32'd0);
    endtask

    task automatic t_alu();
        logic [31:0] w;
        do_reset();
        put(0, ii(8, 0, 1, 10));
        put(1, ii(8, 7, 2, -3));
        put(2, rr(32, 1, 2, 3));
        put(3, rr(34, 2, 1, 4));
        put(4, rr(36, 1, 2, 5));
        put(5, rr(37, 1, 2, 6));
        put(6, rr(42, 2, 1, 7));
        put(7, rr(42, 1, 2, 8));
        for (int i = 0; i < 6; i++) begin
            put(8 + i, ii(43, 0, 3 + i, 192 + 4 * i));
            put(48 + i, 32'hDEADBEEF);
        end
        run_prog(14);
        chk("R4 movi length", lens[1], 32'd4);
        chk("R3 alu length", lens[2], 32'd4);
        chk("R6 store length", lens[8], 32'd4);
        peek(48, w); chk("R3 add", w, 32'd7);
        peek(49, w); chk("R3 sub", w, 32'hFFFFFFF3);
        peek(50, w); chk("R3 and", w, 32'd8);
        peek(51, w); chk("R3 or", w, 32'hFFFFFFFF);
        peek(52, w); chk("R3 slt true signed", w, 32'd1);
        peek(53, w); chk("R3 slt false", w, 32'd0);
        chk("R2 pc after 14", pc_o, 32'd56);
    endtask

    task automatic t_mem();
        logic [31:0] w;
        do_reset();
        put(40, 32'h12345678);
        put(41, 32'hCAFEF00D);
        put(0, ii(35, 0, 1, 160));
        put(1, ii(8, 0, 2, 168));
        put(2, ii(35, 2, 3, -4));
        put(3, ii(43, 2, 1, 8));
        put(4, ii(43, 2, 3, 12));
        run_prog(5);
        chk("R5 load length", lens[0], 32'd5);
        chk("R5 load neg length", lens[2], 32'd5);
        chk("R6 store length", lens[3], 32'd4);
        peek(44, w); chk("R5 load positive offset", w, 32'h12345678);
        peek(45, w); chk("R5 load negative offset", w, 32'hCAFEF00D);
    endtask

    task automatic t_branch();
        logic [31:0] w;
        do_reset();
        put(0, ii(8, 0, 1, 5));
        put(1, ii(8, 0, 2, 5));
        put(2, ii(8, 0, 3, 7));
        put(3, ii(4, 1, 2, 1));
        put(4, ii(8, 0, 3, 99));
        put(5, ii(4, 1, 0, 3));
        put(6, ii(43, 0, 3, 220));
        put(7, ii(4, 0, 0, -1));
        put(55, 32'h0);
        run_prog(8);
        chk("R7 taken length", lens[3], 32'd3);
        chk("R7 not taken length", lens[4], 32'd3);
        chk("R6 store after branches", lens[5], 32'd4);
        chk("R7 backward length", lens[7], 32'd3);
        peek(55, w); chk("R7 skipped instruction", w, 32'd7);
        chk("R7 backward target", pc_o, 32'd28);
    endtask

    task automatic t_unknown_r0();
        logic [31:0] w;
        do_reset();
        put(0, ii(8, 0, 3, 21));
        put(1, ii(63, 1, 3, 5));
        put(2, rr(1, 3, 3, 3));
        put(3, ii(8, 0, 0, 55));
        put(4, ii(43, 0, 0, 224));
        put(5, ii(43, 0, 3, 228));
        put(56, 32'hDEADBEEF);
        put(57, 32'h0);
        run_prog(6);
        chk("R9 unknown opcode length", lens[1], 32'd2);
        chk("R9 bad funct length", lens[2], 32'd2);
        peek(56, w); chk("R8 r0 write dropped", w, 32'd0);
        peek(57, w); chk("R9 r3 untouched", w, 32'd21);
        chk("R9 pc", pc_o, 32'd24);
    endtask

    task automatic t_freeze();
        logic [31:0] w;
        logic [31:0] pc_s;
        logic [31:0] cy_s;
        do_reset();
        put(0, ii(8, 0, 1, 3));
        put(1, ii(43, 0, 1, 232));
        put(58, 32'h0);
        @(negedge clk);
        run = 1'b1;
        repeat (2) @(posedge clk);
        #1 run = 1'b0;
        pc_s = pc_o; cy_s = cycles_o;
        chk("R2 pc after fetch", pc_s, 32'd4);
        chk("R11 cycles counted", cy_s, 32'd2);
        repeat (5) @(negedge clk);
        chk("R10 pc frozen", pc_o, pc_s);
        chk("R10 cycles frozen", cycles_o, cy_s);
        chk("R10 no retire when frozen", {31'd0, retire_o}, 32'd0);
        run_prog(2);
        chk("R10 resumed length", lens[0], 32'd4);
        peek(58, w); chk("R10 resumed result", w, 32'd3);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_alu();
        t_mem();
        t_branch();
        t_unknown_r0();
        t_freeze();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule